// File: doc/BRIEF.md
# Programmable Counter/Timer with Preload

This block is a 16-bit down-counter driven by a host register interface. The host writes a start value as two bytes (high and low), then issues a start strobe. From that point the block counts down once per tick. A tick is either every clock or, with the prescaler enabled, every sixteenth clock. The current count is visible at all times as two byte-wide outputs.

The block has two modes. In counter mode it behaves as a one-shot. The output is high while counting and drops low when the count reaches zero, and a ready flag rises at the same time. The count then keeps decrementing and wraps until the host stops it. In timer mode it makes a square wave. The count reloads from the value captured at start each time it runs out, the output toggles, and the ready flag rises once per full output period. In this mode a stop strobe only clears the flag, and the timer keeps running.

Byte writes to the start value never disturb a run in progress. Every start strobe captures the current start value and begins a fresh cycle. If no new value has been written, the previous value is used again.

Top module: `ctr_timer_top`

## Requirements
- R1: After reset the count outputs are 0x0000, the ready flag is 0, the timer output is 1, and the count does not change until a start strobe.
- R2: A high or low byte write stores that byte of the start value and leaves the count, flag and output unchanged. A start strobe loads the count with {high, low}. A stored value is reused by later starts until it is rewritten.
- R3: In counter mode with the prescaler off, the count falls by exactly one on each clock after the start edge.
- R4: In counter mode the flag sets and the output goes low on the tick where the count reaches 0x0000, which is N ticks after start for a start value N of 1 or more. A start value of 0 instead sets them on the first tick, and the count becomes 0xFFFF. After this the count keeps decrementing and wraps.
- R5: In counter mode a stop strobe freezes the count, clears the flag and drives the output high.
- R6: In timer mode the output is 1 at start and toggles every max(N,1) ticks. At each toggle the count reloads from the value captured at start, so the full period is 2·max(N,1) ticks.
- R7: In timer mode the flag sets on each low-to-high toggle of the output. A stop strobe clears the flag but neither freezes the count nor changes the output.
- R8: With the prescaler enabled, one tick occurs every 16 clocks, counted from the start edge. A counter-mode run with start value N therefore sets the flag 16·N clocks after start, so the largest effective divisor is 16·65535.
- R9: A start strobe during a run restarts from the current start value, clears the flag, drives the output high and restarts the prescaler. If start and stop arrive in the same cycle, start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrHi | input | 1 | Write strobe, start value high byte |
| wrLo | input | 1 | Write strobe, start value low byte |
| wrData | input | 8 | Byte written by wrHi or wrLo |
| startCmd | input | 1 | Start strobe (one clock) |
| stopCmd | input | 1 | Stop strobe (one clock) |
| modeTimer | input | 1 | 1 = square-wave timer mode, 0 = counter mode |
| prescaleEn | input | 1 | 1 = one tick per 16 clocks |
| countHi | output | 8 | Current count, high byte |
| countLo | output | 8 | Current count, low byte |
| readyFlag | output | 1 | Ready status for the interrupt logic |
| timerOut | output | 1 | Counter/timer output for pin routing |

## Verification
The assertions check several properties on every cycle: the one-step decrement of a running counter, the effect of a stop in each mode, the cleared flag and high output after every start, and that in counter mode the output only falls when the flag is set. Only the bench's scenarios, driven against a cycle-accurate behavioural model, can show the rest. That covers the exact cycle of terminal count for start values 0, 1 and larger, the wrap to 0xFFFF, reuse of an old start value, the square-wave period, the sixteen-clock prescaled timing, and the start-over-stop priority.

// File: rtl/ctr_timer_pkg.sv
package ctr_timer_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture start value and load the count
    logic dec;     // count <= count - 1
    logic reload;  // count <= captured start value
  } ctStrobe_t;
endpackage

// File: rtl/ctr_timer_dp.sv
module ctr_timer_dp
  import ctr_timer_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrHi,
  input  logic              wrLo,
  input  logic [BYTE_W-1:0] wrData,
  input  ctStrobe_t         strobe,
  output logic [CNT_W-1:0]  countVal,
  output logic              atEnd
);
  logic [BYTE_W-1:0] preHi, preLo;
  logic [CNT_W-1:0]  shadow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preHi <= '0;
      preLo <= '0;
    end else begin
      if (wrHi) preHi <= wrData;
      if (wrLo) preLo <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow   <= '0;
      countVal <= '0;
    end else if (strobe.load) begin
      shadow   <= {preHi, preLo};
      countVal <= {preHi, preLo};
    end else if (strobe.reload) begin
      countVal <= shadow;
    end else if (strobe.dec) begin
      countVal <= countVal - CNT_W'(1);
    end
  end

  // terminal condition: this tick takes the count to zero (or it is already zero)
  assign atEnd = (countVal <= CNT_W'(1));
endmodule

// File: rtl/ctr_timer_ctrl.sv
module ctr_timer_ctrl
  import ctr_timer_pkg::*;
#(
  parameter int PSC_W = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startCmd,
  input  logic      stopCmd,
  input  logic      modeTimer,
  input  logic      prescaleEn,
  input  logic      atEnd,
  output ctStrobe_t strobe,
  output logic      running,
  output logic      readyFlag,
  output logic      timerOut
);
  logic [PSC_W-1:0] psc;
  logic tick, haltNow;

  assign tick    = running && (!prescaleEn || (psc == '1));
  assign haltNow = stopCmd && !modeTimer;

  always_comb begin
    strobe        = '0;
    strobe.load   = startCmd;
    if (!startCmd && tick && !haltNow) begin
      strobe.reload = modeTimer && atEnd;
      strobe.dec    = !(modeTimer && atEnd);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      readyFlag <= 1'b0;
      timerOut  <= 1'b1;
      psc       <= '0;
    end else if (startCmd) begin
      running   <= 1'b1;
      readyFlag <= 1'b0;
      timerOut  <= 1'b1;
      psc       <= '0;
    end else begin
      if (running && prescaleEn) psc <= psc + PSC_W'(1);
      if (haltNow) begin
        running   <= 1'b0;
        readyFlag <= 1'b0;
        timerOut  <= 1'b1;
      end else begin
        if (tick && atEnd) begin
          if (modeTimer) begin
            timerOut <= ~timerOut;
            if (!timerOut) readyFlag <= 1'b1;
          end else begin
            readyFlag <= 1'b1;
            timerOut  <= 1'b0;
          end
        end
        if (stopCmd) readyFlag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctr_timer_top.sv
module ctr_timer_top
  import ctr_timer_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PSC_W  = 4,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrHi,
  input  logic              wrLo,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              startCmd,
  input  logic              stopCmd,
  input  logic              modeTimer,
  input  logic              prescaleEn,
  output logic [BYTE_W-1:0] countHi,
  output logic [BYTE_W-1:0] countLo,
  output logic              readyFlag,
  output logic              timerOut
);
  ctStrobe_t        strobe;
  logic [CNT_W-1:0] countVal;
  logic             atEnd;
  logic             running;

  ctr_timer_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrHi(wrHi), .wrLo(wrLo), .wrData(wrData),
    .strobe(strobe), .countVal(countVal), .atEnd(atEnd)
  );

  ctr_timer_ctrl #(.PSC_W(PSC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .stopCmd(stopCmd),
    .modeTimer(modeTimer), .prescaleEn(prescaleEn), .atEnd(atEnd),
    .strobe(strobe), .running(running), .readyFlag(readyFlag),
    .timerOut(timerOut)
  );

  assign countHi = countVal[CNT_W-1:BYTE_W];
  assign countLo = countVal[BYTE_W-1:0];
endmodule

// File: rtl/ctr_timer_chk.sv
module ctr_timer_chk #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              startCmd,
  input logic              stopCmd,
  input logic              modeTimer,
  input logic              prescaleEn,
  input logic              running,
  input logic [BYTE_W-1:0] countHi,
  input logic [BYTE_W-1:0] countLo,
  input logic              readyFlag,
  input logic              timerOut
);
  logic [CNT_W-1:0] cnt;
  assign cnt = {countHi, countLo};

  a_r3_counter_dec: assert property (@(posedge clk) disable iff (!rstN)
    (running && !modeTimer && !prescaleEn && !startCmd && !stopCmd)
      |=> (cnt == CNT_W'($past(cnt) - CNT_W'(1))));

  a_r5_counter_stop: assert property (@(posedge clk) disable iff (!rstN)
    (stopCmd && !startCmd && !modeTimer)
      |=> ($stable(cnt) && !readyFlag && timerOut));

  a_r7_timer_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stopCmd && !startCmd && modeTimer) |=> !readyFlag);

  a_r9_start_fresh: assert property (@(posedge clk) disable iff (!rstN)
    startCmd |=> (!readyFlag && timerOut));

  a_r4_low_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(timerOut) && !$past(modeTimer)) |-> readyFlag);
endmodule

bind ctr_timer_top ctr_timer_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .startCmd(startCmd), .stopCmd(stopCmd),
  .modeTimer(modeTimer), .prescaleEn(prescaleEn), .running(running),
  .countHi(countHi), .countLo(countLo), .readyFlag(readyFlag),
  .timerOut(timerOut)
);

// File: tb/ctr_timer_top_bench.sv
`timescale 1ns/1ps
module ctr_timer_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrHi = 0, wrLo = 0, startCmd = 0, stopCmd = 0, modeTimer = 0, prescaleEn = 0;
  logic [7:0] wrData = 0;
  logic [7:0] countHi, countLo;
  logic readyFlag, timerOut;

  int nChecks = 0, nFails = 0, cyc = 0;

  always #10 clk = ~clk;   // 50 MHz

  ctr_timer_top u_ctr_timer_top (
    .clk(clk), .rstN(rstN), .wrHi(wrHi), .wrLo(wrLo), .wrData(wrData),
    .startCmd(startCmd), .stopCmd(stopCmd), .modeTimer(modeTimer),
    .prescaleEn(prescaleEn), .countHi(countHi), .countLo(countLo),
    .readyFlag(readyFlag), .timerOut(timerOut)
  );

  // behavioural reference model
  int mPre = 0, mShadow = 0, mCnt = 0, mPsc = 0;
  bit mRun = 0, mRdy = 0, mOut = 1;

  always @(posedge clk) begin
    bit tk;
    cyc++;
    if (!rstN) begin
      mPre = 0; mShadow = 0; mCnt = 0; mPsc = 0; mRun = 0; mRdy = 0; mOut = 1;
    end else begin
      tk = mRun && (!prescaleEn || mPsc == 15);
      if (startCmd) begin
        mShadow = mPre; mCnt = mPre; mRun = 1; mRdy = 0; mOut = 1; mPsc = 0;
      end else begin
        if (mRun && prescaleEn) mPsc = (mPsc + 1) % 16;
        if (stopCmd && !modeTimer) begin
          mRun = 0; mRdy = 0; mOut = 1;
        end else begin
          if (tk) begin
            if (modeTimer) begin
              if (mCnt <= 1) begin
                mCnt = mShadow;
                if (!mOut) mRdy = 1;
                mOut = !mOut;
              end else mCnt = mCnt - 1;
            end else begin
              if (mCnt <= 1) begin mRdy = 1; mOut = 0; end
              mCnt = (mCnt + 65535) % 65536;
            end
          end
          if (stopCmd) mRdy = 0;
        end
      end
      if (wrHi) mPre = (mPre & 'h00FF) | (int'(wrData) << 8);
      if (wrLo) mPre = (mPre & 'hFF00) | int'(wrData);
    end
  end

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) if (rstN) begin
    chk("R2/R3 count", {countHi, countLo}, mCnt);
    chk("R4/R7 flag", readyFlag, mRdy);
    chk("R4/R6 output", timerOut, mOut);
  end

  always @(posedge clk) if (cyc > 150000) begin
    nFails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  task automatic writePre(int v);
    @(negedge clk); wrHi = 1; wrData = 8'(v >> 8);
    @(negedge clk); wrHi = 0; wrLo = 1; wrData = 8'(v);
    @(negedge clk); wrLo = 0;
  endtask
  task automatic pulseStart();
    @(negedge clk); startCmd = 1;
    @(negedge clk); startCmd = 0;
  endtask
  task automatic pulseStop();
    @(negedge clk); stopCmd = 1;
    @(negedge clk); stopCmd = 0;
  endtask
  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int held;
    waitClk(3);
    chk("R1 count", {countHi, countLo}, 0);
    chk("R1 flag", readyFlag, 0);
    chk("R1 out", timerOut, 1);
    rstN = 1;
    waitClk(5);
    chk("R1 idle", {countHi, countLo}, 0);

    // counter mode, N=5
    writePre(16'h0005);
    chk("R2 write no effect", {countHi, countLo}, 0);
    pulseStart();
    chk("R2 load", {countHi, countLo}, 5);
    waitClk(4);
    chk("R3 dec", {countHi, countLo}, 1);
    chk("R4 not yet", readyFlag, 0);
    waitClk(1);
    chk("R4 terminal flag", readyFlag, 1);
    chk("R4 terminal out", timerOut, 0);
    waitClk(2);
    chk("R4 wrap", {countHi, countLo}, 16'hFFFE);
    pulseStop();
    chk("R5 frozen", {countHi, countLo}, 16'hFFFD);
    chk("R5 flag", readyFlag, 0);
    chk("R5 out", timerOut, 1);
    writePre(16'h0103);
    chk("R2 write while stopped", {countHi, countLo}, 16'hFFFD);
    pulseStart();
    chk("R2 new value", {countHi, countLo}, 16'h0103);
    pulseStop();
    pulseStart();
    chk("R2 reuse", {countHi, countLo}, 16'h0103);
    pulseStop();

    // start value zero
    writePre(0);
    pulseStart();
    waitClk(1);
    chk("R4 zero flag", readyFlag, 1);
    chk("R4 zero wrap", {countHi, countLo}, 16'hFFFF);
    pulseStop();

    // timer mode, N=4
    modeTimer = 1;
    writePre(4);
    pulseStart();
    waitClk(3);
    chk("R6 high before", timerOut, 1);
    waitClk(1);
    chk("R6 first toggle", timerOut, 0);
    chk("R6 reload", {countHi, countLo}, 4);
    waitClk(4);
    chk("R7 period flag", readyFlag, 1);
    chk("R6 second toggle", timerOut, 1);
    held = {countHi, countLo};
    pulseStop();
    chk("R7 stop clears", readyFlag, 0);
    chk("R7 keeps running", ({countHi, countLo} != held), 1);
    waitClk(20);
    // restart mid-run
    pulseStart();
    chk("R9 restart", {countHi, countLo}, 4);
    chk("R9 out", timerOut, 1);
    modeTimer = 0;
    pulseStop();

    // prescaler, counter mode N=2
    prescaleEn = 1;
    writePre(2);
    pulseStart();
    waitClk(15);
    chk("R8 before tick", {countHi, countLo}, 2);
    waitClk(1);
    chk("R8 first tick", {countHi, countLo}, 1);
    waitClk(15);
    chk("R8 no flag yet", readyFlag, 0);
    waitClk(1);
    chk("R8 flag at 32", readyFlag, 1);
    prescaleEn = 0;

    // start and stop together
    @(negedge clk); startCmd = 1; stopCmd = 1;
    @(negedge clk); startCmd = 0; stopCmd = 0;
    waitClk(1);
    chk("R9 start wins", {countHi, countLo}, 1);
    pulseStop();

    waitClk(3);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule